// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between one peripheral and memory without the processor touching each word. Software loads a peripheral address, a memory start address and a word count, then writes a control word. That control word selects the transfer direction and the bus topology, and it starts the channel. For every word the engine raises a bus request and waits until it samples the grant high. It then owns the bus for one transfer cycle and lets go of the request in the next cycle, so the processor is stalled only at the points where it would have used the bus. No context is saved, so no per-word interrupt is needed. When the last word has moved, a level interrupt is raised. It stays up until software writes the control register again.

Two topologies are supported. In the integrated topology the peripheral has a private port on the engine, so each word uses the shared bus once: the memory side of the move is a bus cycle, and the peripheral side happens on the private port in the same cycle. In the detached topology the peripheral sits on the shared bus in I/O space. Each word then uses two separately granted bus cycles. The first reads the source into an internal holding register, and the second writes the holding register to the destination.

The sequencer has four states. IDLE waits for a start. ASK holds the bus request. MOVE is the single cycle in which the engine owns the bus. GIVE is the cycle in which the request is dropped and the bus is handed back. The transitions are:
- IDLE to ASK on a start with a non-zero count.
- IDLE stays in IDLE on a start with a zero count, and completion is flagged at once.
- ASK to MOVE when the grant is sampled high.
- MOVE to GIVE always.
- GIVE to ASK while a half-word or words remain.
- GIVE to IDLE, with completion flagged, once the count is zero.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset `bus_req`, `bus_act` and `irq` are low, and the status register (select 4) reads 0.
- R2: A start (a write to select 0 with bit 0 set) with a non-zero count raises `bus_req` in the next cycle. `bus_req` stays high for as long as `bus_gnt` is sampled low.
- R3: `bus_act` is high for exactly one cycle and only in the cycle after `bus_req` and `bus_gnt` were both high. `bus_req` is low in the cycle after every `bus_act` cycle.
- R4: In integrated mode with control bit 1 = 0 (peripheral to memory), each word is one bus write (`bus_we`=1, `bus_io`=0) at the current memory address. The data is `dev_rdata`, and `dev_rd` is pulsed in that cycle.
- R5: In integrated mode with control bit 1 = 1 (memory to peripheral), each word is one bus read of the current memory address. `dev_wr` is pulsed in that cycle, with `dev_wdata` equal to the word read.
- R6: In detached mode (control bit 2 = 1), each word is two granted bus cycles. The first reads the source and the second writes that value to the destination. The peripheral side uses `bus_io`=1 with the programmed peripheral address, and `bus_req` drops between the two cycles.
- R7: The memory address advances by one and the count drops by one per completed word. At completion the memory address register (select 2) reads start+N and the count register (select 3) reads 0.
- R8: `irq` rises two cycles after the last word's `bus_act` cycle and stays high until the next control write.
- R9: A start with a count of 0 raises `irq` in the next cycle and issues no bus request.
- R10: Any control write made while idle clears `irq` and the done flag.
- R11: Writes to any programming register while the channel is busy are ignored.
- R12: The status register (select 4) reads bit 0 = busy and bit 1 = done. The control register (select 0) reads back the direction in bit 1 and the mode in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Programming write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 peripheral address, 2 memory address, 3 count, 4 status |
| cfg_wdata | input | ADDR_W | Programming write data |
| cfg_rdata | output | ADDR_W | Read data for the selected register |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| bus_act | output | 1 | Engine owns the bus this cycle |
| bus_io | output | 1 | Bus cycle targets I/O space (peripheral) |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid in the active cycle |
| dev_rd | output | 1 | Integrated-mode peripheral read strobe |
| dev_rdata | input | DATA_W | Integrated-mode peripheral data in |
| dev_wr | output | 1 | Integrated-mode peripheral write strobe |
| dev_wdata | output | DATA_W | Integrated-mode peripheral data out |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The bench attacks the grant handshake with a randomly withheld grant. A design that sampled the grant too early, or that held the bus across words, would show a transfer without a grant or a request that stays high after the active cycle. Each detached word is checked as two separately granted cycles, with the holding register feeding the second. A design that wrote stale or wrong holding data would put a mismatching value on the bus.

The bench also covers a start with a zero count, which must complete with no bus request at all. It covers programming writes while the channel is busy, which would otherwise redirect the remaining addresses or alter the final counters. Finally, it compares the interrupt every cycle, so a completion flag that arrived one cycle early or late, or that was not cleared by the control write, is caught.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASK,
        ST_MOVE,
        ST_GIVE
    } dma_state_e;

    // register selects
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_DEV  = 3'd1;
    localparam logic [2:0] SEL_MEM  = 3'd2;
    localparam logic [2:0] SEL_CNT  = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    // control word bits
    localparam int unsigned CTRL_GO  = 0;
    localparam int unsigned CTRL_DIR = 1;
    localparam int unsigned CTRL_DET = 2;

    // status word bits
    localparam int unsigned STAT_BUSY = 0;
    localparam int unsigned STAT_DONE = 1;

endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
    import dma_steal_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic              start_req,
    output logic              dir,
    output logic              det,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CNT_W-1:0]  count,
    output logic              done
);

    logic prog_wr;
    logic ctrl_wr;

    assign prog_wr   = cfg_wr && !busy;
    assign ctrl_wr   = prog_wr && (cfg_sel == SEL_CTRL);
    assign start_req = ctrl_wr && cfg_wdata[CTRL_GO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir      <= 1'b0;
            det      <= 1'b0;
            dev_addr <= '0;
            mem_addr <= '0;
            count    <= '0;
            done     <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                dir <= cfg_wdata[CTRL_DIR];
                det <= cfg_wdata[CTRL_DET];
            end
            if (prog_wr && cfg_sel == SEL_DEV) begin
                dev_addr <= cfg_wdata[DEV_W-1:0];
            end
            if (prog_wr && cfg_sel == SEL_MEM) begin
                mem_addr <= cfg_wdata;
            end else if (step) begin
                mem_addr <= mem_addr + 1'b1;
            end
            if (prog_wr && cfg_sel == SEL_CNT) begin
                count <= cfg_wdata[CNT_W-1:0];
            end else if (step) begin
                count <= count - 1'b1;
            end
            // set has priority so a zero-count start still completes
            if (finish) begin
                done <= 1'b1;
            end else if (ctrl_wr) begin
                done <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_CTRL: begin
                cfg_rdata[CTRL_DIR] = dir;
                cfg_rdata[CTRL_DET] = det;
            end
            SEL_DEV:  cfg_rdata = ADDR_W'(dev_addr);
            SEL_MEM:  cfg_rdata = mem_addr;
            SEL_CNT:  cfg_rdata = ADDR_W'(count);
            SEL_STAT: begin
                cfg_rdata[STAT_BUSY] = busy;
                cfg_rdata[STAT_DONE] = done;
            end
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_steal_fsm.sv
module dma_steal_fsm
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic count_zero,
    input  logic det,
    input  logic bus_gnt,
    output logic phase,
    output logic busy,
    output logic step,
    output logic finish,
    output logic hold_ld,
    output logic bus_req,
    output logic bus_act
);

    dma_state_e state, state_nx;

    // state register; phase marks the second half of a detached word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_MOVE) begin
                phase <= det && !phase;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_req && !count_zero) state_nx = ST_ASK;
            ST_ASK:  if (bus_gnt) state_nx = ST_MOVE;
            ST_MOVE: state_nx = ST_GIVE;
            ST_GIVE: state_nx = (count_zero && !phase) ? ST_IDLE : ST_ASK;
        endcase
    end

    always_comb begin
        bus_req = (state == ST_ASK) || (state == ST_MOVE);
        bus_act = (state == ST_MOVE);
        busy    = (state != ST_IDLE);
        hold_ld = (state == ST_MOVE) && det && !phase;
        step    = (state == ST_MOVE) && !(det && !phase);
        finish  = ((state == ST_IDLE) && start_req && count_zero) ||
                  ((state == ST_GIVE) && !phase && count_zero);
    end

endmodule

// File: rtl/dma_steal_path.sv
module dma_steal_path #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_act,
    input  logic              phase,
    input  logic              hold_ld,
    input  logic              dir,
    input  logic              det,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              bus_io,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata
);

    localparam logic [ADDR_W-1:0] IO_BASE = '0;

    logic [DATA_W-1:0] hold_q;
    logic [ADDR_W-1:0] io_addr;
    logic              src_is_dev;

    assign io_addr    = IO_BASE | ADDR_W'(dev_addr);
    assign src_is_dev = !dir;
    assign dev_wdata  = bus_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_ld) begin
            hold_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_io    = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        if (bus_act) begin
            if (!det) begin
                bus_addr = mem_addr;
                if (src_is_dev) begin
                    bus_we    = 1'b1;
                    bus_wdata = dev_rdata;
                    dev_rd    = 1'b1;
                end else begin
                    dev_wr = 1'b1;
                end
            end else if (!phase) begin
                // first half: read the source into the holding register
                bus_io   = src_is_dev;
                bus_addr = src_is_dev ? io_addr : mem_addr;
            end else begin
                // second half: write the holding register to the destination
                bus_io    = !src_is_dev;
                bus_we    = 1'b1;
                bus_addr  = src_is_dev ? mem_addr : io_addr;
                bus_wdata = hold_q;
            end
        end
    end

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_act,
    output logic              bus_io,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              dev_rd,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              irq
);

    logic              busy, step, finish, start_req, phase, hold_ld;
    logic              dir, det, done, count_zero;
    logic [DEV_W-1:0]  dev_addr;
    logic [ADDR_W-1:0] mem_addr;
    logic [CNT_W-1:0]  count;

    assign count_zero = (count == '0);
    assign irq        = done;

    dma_steal_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DEV_W  (DEV_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .start_req (start_req),
        .dir       (dir),
        .det       (det),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .count     (count),
        .done      (done)
    );

    dma_steal_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .count_zero (count_zero),
        .det        (det),
        .bus_gnt    (bus_gnt),
        .phase      (phase),
        .busy       (busy),
        .step       (step),
        .finish     (finish),
        .hold_ld    (hold_ld),
        .bus_req    (bus_req),
        .bus_act    (bus_act)
    );

    dma_steal_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEV_W  (DEV_W)
    ) i_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_act   (bus_act),
        .phase     (phase),
        .hold_ld   (hold_ld),
        .dir       (dir),
        .det       (det),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .bus_rdata (bus_rdata),
        .dev_rdata (dev_rdata),
        .bus_io    (bus_io),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dev_rd    (dev_rd),
        .dev_wr    (dev_wr),
        .dev_wdata (dev_wdata)
    );

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [2:0] cfg_sel,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       bus_act,
    input logic       bus_io,
    input logic       bus_we,
    input logic       dev_rd,
    input logic       dev_wr,
    input logic       irq
);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !bus_act) |=> bus_req);

    assert_act_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |-> ($past(bus_req) && $past(bus_gnt)));

    assert_release_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |=> !bus_req);

    assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |=> !bus_act);

    assert_dev_read_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> (bus_act && bus_we && !bus_io));

    assert_dev_write_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (bus_act && !bus_we && !bus_io));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cfg_wr && cfg_sel == 3'd0)) |=> irq);

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!bus_req && !bus_act));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rd, dev_wr}));

endmodule

bind dma_steal_ctrl dma_steal_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_sel (cfg_sel),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_act (bus_act),
    .bus_io  (bus_io),
    .bus_we  (bus_we),
    .dev_rd  (dev_rd),
    .dev_wr  (dev_wr),
    .irq     (irq)
);

// File: tb/test_dma_steal_ctrl.sv
`timescale 1ns/1ps
module test_dma_steal_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_act, bus_io, bus_we, dev_rd, dev_wr, irq;
    logic        bus_gnt = 1'b0;
    logic [15:0] bus_addr, bus_wdata, bus_rdata, dev_rdata, dev_wdata;

    always #5 clk = ~clk;

    dma_steal_ctrl i_dma_steal_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_act(bus_act), .bus_io(bus_io), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .irq(irq)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural memory and peripheral
    logic [15:0] mem [0:255];
    logic [15:0] dev_src = 16'h0;
    logic [15:0] dev_val;
    assign dev_val   = 16'hA000 + dev_src;
    assign dev_rdata = dev_val;
    assign bus_rdata = bus_io ? dev_val : mem[bus_addr[7:0]];

    // expected bus operations
    int q_io[$], q_we[$], q_addr[$], q_data[$];
    bit    cur_dir = 0, cur_det = 0;
    string cur_tag = "R4";
    bit    exp_irq = 0;
    int    tail = 0;
    int    cnt_model = 0;
    bit    gnt_block = 0;

    bit prev_req = 0, prev_gnt = 0, prev_act = 0;
    bit pm_we = 0, pm_src = 0;
    logic [7:0]  pm_addr = 8'h0;
    logic [15:0] pm_data = 16'h0;

    always @(posedge clk) begin
        if (pm_we) mem[pm_addr] <= pm_data;
        if (pm_src) dev_src <= dev_src + 16'h1;
    end

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (tail > 0) begin
                tail--;
                if (tail == 0) exp_irq = 1;
            end
            chk(irq === exp_irq, "R8 irq per cycle", irq, exp_irq);
            if (prev_act) chk(!bus_req, "R3 request dropped after word", bus_req, 0);
            if (prev_req && !prev_gnt && !prev_act) chk(bus_req, "R2 request held", bus_req, 1);
            pm_we  = 0;
            pm_src = 0;
            if (bus_act) begin
                chk(prev_req && prev_gnt, "R3 transfer only after grant", {prev_req, prev_gnt}, 2'b11);
                if (q_io.size() == 0) begin
                    chk(0, "R3 unexpected transfer", bus_addr, 0);
                end else begin
                    int e_io, e_we, e_addr, e_data;
                    logic [15:0] a_data;
                    e_io = q_io.pop_front(); e_we = q_we.pop_front();
                    e_addr = q_addr.pop_front(); e_data = q_data.pop_front();
                    chk(bus_io == e_io[0] && bus_we == e_we[0], {cur_tag, " cycle kind"},
                        {bus_io, bus_we}, {e_io[0], e_we[0]});
                    chk(bus_addr == e_addr[15:0], {cur_tag, " R7 address"}, bus_addr, e_addr);
                    a_data = bus_we ? bus_wdata : dev_wdata;
                    if (e_data >= 0) chk(a_data == e_data[15:0], {cur_tag, " data"}, a_data, e_data);
                    chk(dev_rd == (!cur_det && !cur_dir), "R4 dev_rd strobe", dev_rd, !cur_det && !cur_dir);
                    chk(dev_wr == (!cur_det && cur_dir), "R5 dev_wr strobe", dev_wr, !cur_det && cur_dir);
                    if (q_io.size() == 0) tail = 2;
                end
                pm_we   = bus_we && !bus_io;
                pm_addr = bus_addr[7:0];
                pm_data = bus_wdata;
                pm_src  = (bus_io && !bus_we) || dev_rd;
            end
            prev_req = bus_req;
            prev_act = bus_act;
            bus_gnt  = bus_req && !gnt_block && ($urandom % 3 != 0);
            prev_gnt = bus_gnt;
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [15:0] val);
        bit was_busy;
        was_busy = (q_io.size() != 0) || (tail > 0);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (!was_busy) begin
            if (sel == 3'd3) cnt_model = val[7:0];
            if (sel == 3'd0) exp_irq = val[0] && (cnt_model == 0);
        end
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [15:0] val);
        @(posedge clk); #1;
        cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    task automatic wait_irq();
        int n;
        n = 0;
        while (irq !== 1'b1 && n < 3000) begin
            @(posedge clk); #2;
            n++;
        end
        chk(irq === 1'b1, "R8 completion interrupt", irq, 1);
    endtask

    task automatic run_xfer(input bit dir, input bit det, input logic [7:0] dev,
                            input logic [15:0] start, input int n, input bit poke_busy);
        logic [15:0] rd;
        logic [15:0] base;
        cur_dir = dir; cur_det = det;
        cur_tag = det ? "R6" : (dir ? "R5" : "R4");
        base = dev_src;
        cfg_write(3'd1, {8'h0, dev});
        cfg_write(3'd2, start);
        cfg_write(3'd3, n[15:0]);
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            a = start + i[15:0];
            if (!det && !dir) begin
                q_io.push_back(0); q_we.push_back(1); q_addr.push_back(a); q_data.push_back(base + 16'hA000 + i[15:0]);
            end else if (!det && dir) begin
                q_io.push_back(0); q_we.push_back(0); q_addr.push_back(a); q_data.push_back(mem[a[7:0]]);
            end else if (det && !dir) begin
                q_io.push_back(1); q_we.push_back(0); q_addr.push_back(dev); q_data.push_back(-1);
                q_io.push_back(0); q_we.push_back(1); q_addr.push_back(a); q_data.push_back(base + 16'hA000 + i[15:0]);
            end else begin
                q_io.push_back(0); q_we.push_back(0); q_addr.push_back(a); q_data.push_back(-1);
                q_io.push_back(1); q_we.push_back(1); q_addr.push_back(dev); q_data.push_back(mem[a[7:0]]);
            end
        end
        cfg_write(3'd0, {13'h0, det, dir, 1'b1});
        cfg_read(3'd4, rd);
        chk(rd[1:0] == 2'b01, "R12 status busy while running", rd, 1);
        if (poke_busy) begin
            // R11: these must all be ignored
            cfg_write(3'd2, 16'h00F0);
            cfg_write(3'd3, 16'h0033);
            cfg_write(3'd1, 16'h0077);
            cfg_write(3'd0, 16'h0001);
        end
        wait_irq();
        chk(q_io.size() == 0, {cur_tag, " all words moved"}, q_io.size(), 0);
        cfg_read(3'd2, rd);
        chk(rd == start + n[15:0], "R7 final memory address", rd, start + n[15:0]);
        cfg_read(3'd3, rd);
        chk(rd == 16'h0, "R7 final count", rd, 0);
        cfg_read(3'd1, rd);
        chk(rd == {8'h0, dev}, "R11 peripheral address kept", rd, dev);
        cfg_read(3'd4, rd);
        chk(rd[1:0] == 2'b10, "R12 status done", rd, 2);
        cfg_read(3'd0, rd);
        chk(rd[2:1] == {det, dir}, "R12 control readback", rd[2:1], {det, dir});
        cfg_write(3'd0, 16'h0000);
        cnt_model = 0;
        chk(irq == 1'b0, "R10 control write clears irq", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        for (int i = 0; i < 256; i++) mem[i] = 16'hC300 + i[15:0];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        chk(!bus_req && !bus_act && !irq, "R1 outputs after reset", {bus_req, bus_act, irq}, 0);
        cfg_read(3'd4, rd);
        chk(rd == 16'h0, "R1 status after reset", rd, 0);

        run_xfer(1'b0, 1'b0, 8'h21, 16'h0010, 5, 1'b0);
        run_xfer(1'b1, 1'b0, 8'h22, 16'h0040, 4, 1'b0);
        // long grant stall to exercise R2
        gnt_block = 1;
        fork
            run_xfer(1'b0, 1'b1, 8'h35, 16'h0060, 4, 1'b1);
            begin repeat (12) @(posedge clk); gnt_block = 0; end
        join
        run_xfer(1'b1, 1'b1, 8'h36, 16'h0010, 3, 1'b0);
        run_xfer(1'b0, 1'b0, 8'h01, 16'h00FF, 1, 1'b0);

        // R9: zero-count start
        cfg_write(3'd3, 16'h0000);
        cfg_write(3'd0, 16'h0001);
        chk(irq == 1'b1, "R9 zero count completes at once", irq, 1);
        repeat (5) begin
            @(posedge clk); #2;
            chk(!bus_req, "R9 no request for zero count", bus_req, 0);
        end
        cfg_read(3'd4, rd);
        chk(rd[1:0] == 2'b10, "R9 status done idle", rd, 2);
        cfg_write(3'd0, 16'h0000);
        chk(irq == 1'b0, "R10 clear after zero count", irq, 0);

        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule